// File: doc/BRIEF.md
# Output-Contention Max-Weight Arbiter

This block settles output contention for a bus-based cell switch before any cell leaves its input queue. In each cell slot every input may present a request. A request carries a destination bit mask, with one bit per output, and an unsigned weight. For every output the block finds the requesting input with the greatest weight. It does this with a pipelined tree of pairwise comparators that is log2(N) stages deep. It then issues one grant bit per input. Because of this, no output is ever offered two cells in the same slot.

Masks with one bit set (unicast), several bits set (multicast) or every bit set (broadcast) all go through the same comparators. An input whose mask covers several outputs is granted only if it wins every one of those outputs. Otherwise it gets no grant and keeps its cell for a later slot. Grants for a slot appear together with a grant-valid strobe a fixed 2 + log2(N) cycles after the slot start pulse. A new slot may begin on every clock.

Top module: `maxwt_out_arbiter`

## Requirements
- R1: For each output, the input that wins is the participating input with the largest weight among those whose mask includes that output.
- R2: When two or more participating inputs share the largest weight for an output, the input with the lowest index wins that output.
- R3: In any slot, the granted inputs have mask bit o set for at most one input, for every output o.
- R4: `grant_vld` is high for exactly one cycle, 2 + log2(N_PORTS) clock cycles after the cycle in which `slot_start` was sampled high. `grant` is all zeros whenever `grant_vld` is low.
- R5: An input whose `req_vld` bit is low, or whose mask is all zeros, takes no part in any comparison and receives no grant.
- R6: An input with several mask bits set is granted only if it wins every output in its mask. If it loses any of them, its grant bit stays 0. Outputs it did win are then left idle for that slot.
- R7: A broadcast mask (all bits set) is resolved by the same rules as R1, R2 and R6, with no special case.
- R8: Slots started on consecutive cycles are resolved independently. Their grants appear on consecutive cycles in start order.
- R9: Request inputs sampled while `slot_start` is low are ignored, and `grant_vld` does not rise for them.
- R10: Mask bit `req_mask[i*N_PORTS + o]` means input i asks for output o. Input i's weight is `req_wt[i*WT_W +: WT_W]`, and grant bit i belongs to input i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Pulse that samples all request inputs for one slot |
| req_vld | input | N_PORTS | Per-input request present |
| req_wt | input | N_PORTS*WT_W | Per-input unsigned weight, input i at bits i*WT_W |
| req_mask | input | N_PORTS*N_PORTS | Per-input destination mask, input i at bits i*N_PORTS |
| grant | output | N_PORTS | Per-input grant for the slot shown by grant_vld |
| grant_vld | output | 1 | Strobe that marks a slot's grants |

## Verification
Two functions can fall in the same cycle. One is the multicast hold-back on an output. The other is a competing unicast that loses that output to the multicast input yet would win everywhere else. The broadcast case provokes both at once. A broadcast input beats a unicast input on one output but loses another output through a weight tie. The expected outcome is judged at the ports: both inputs are refused, and only the tie winner is granted. Pipelined slots on back-to-back cycles are also checked, each against its own hand-computed grant vector, so that results from neighbouring slots cannot leak into one another.

// File: rtl/mwarb_pkg.sv
package mwarb_pkg;
   localparam int unsigned WT_MAX    = 8;
   localparam int unsigned PORTS_MIN = 4;
   localparam int unsigned PORTS_MAX = 16;
   localparam int unsigned WT_MIN    = 4;

   // Left operand is kept on equal weight, so the lower input index survives.
   function automatic logic left_wins(input logic l_vld, input logic r_vld,
                                      input logic [WT_MAX-1:0] l_wt,
                                      input logic [WT_MAX-1:0] r_wt);
      return l_vld && (!r_vld || (l_wt >= r_wt));
   endfunction
endpackage

// File: rtl/mwarb_node.sv
module mwarb_node #(
   parameter int unsigned WT_W  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_vld,
   input  logic [WT_W-1:0]  l_wt,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             r_vld,
   input  logic [WT_W-1:0]  r_wt,
   input  logic [IDX_W-1:0] r_idx,
   output logic             y_vld,
   output logic [WT_W-1:0]  y_wt,
   output logic [IDX_W-1:0] y_idx
);
   import mwarb_pkg::*;

   logic take_l;

   always_comb take_l = left_wins(l_vld, r_vld, WT_MAX'(l_wt), WT_MAX'(r_wt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_vld <= 1'b0;
         y_wt  <= '0;
         y_idx <= '0;
      end else begin
         y_vld <= l_vld | r_vld;
         y_wt  <= take_l ? l_wt  : r_wt;
         y_idx <= take_l ? l_idx : r_idx;
      end
   end

   p_pair_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (l_vld && r_vld) |=> (y_wt >= $past(l_wt)) && (y_wt >= $past(r_wt)));

   p_tie_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (l_vld && r_vld && (l_wt == r_wt)) |=> (y_idx == $past(l_idx)));

   p_idle_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_vld && !r_vld) |=> !y_vld);
endmodule

// File: rtl/mwarb_tree.sv
module mwarb_tree #(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned WT_W    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          leaf_vld,
   input  logic [N_PORTS*WT_W-1:0]     leaf_wt,
   output logic                        win_vld,
   output logic [$clog2(N_PORTS)-1:0]  win_idx
);
   localparam int unsigned IDX_W = $clog2(N_PORTS);
   localparam int unsigned LVLS  = IDX_W;
   localparam int unsigned NODES = 2*N_PORTS - 1;
   localparam int unsigned FIRST_LEAF = N_PORTS - 1;

   // Heap layout: node j has children 2j+1 (left, lower inputs) and 2j+2.
   logic [NODES-1:0] h_vld;
   logic [WT_W-1:0]  h_wt  [NODES];
   logic [IDX_W-1:0] h_idx [NODES];

   for (genvar i = 0; i < N_PORTS; i++) begin : g_leaf
      assign h_vld[FIRST_LEAF+i] = leaf_vld[i];
      assign h_wt[FIRST_LEAF+i]  = leaf_wt[i*WT_W +: WT_W];
      assign h_idx[FIRST_LEAF+i] = IDX_W'(i);
   end

   for (genvar j = 0; j < FIRST_LEAF; j++) begin : g_node
      mwarb_node #(.WT_W(WT_W), .IDX_W(IDX_W)) u_node (
         .clk   (clk),
         .rst_n (rst_n),
         .l_vld (h_vld[2*j+1]),
         .l_wt  (h_wt[2*j+1]),
         .l_idx (h_idx[2*j+1]),
         .r_vld (h_vld[2*j+2]),
         .r_wt  (h_wt[2*j+2]),
         .r_idx (h_idx[2*j+2]),
         .y_vld (h_vld[j]),
         .y_wt  (h_wt[j]),
         .y_idx (h_idx[j])
      );
   end

   assign win_vld = h_vld[0];
   assign win_idx = h_idx[0];

   for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
      p_root_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
         $past(leaf_vld[i], LVLS) |->
            (win_vld && (h_wt[0] >= $past(leaf_wt[i*WT_W +: WT_W], LVLS))));
   end
endmodule

// File: rtl/mwarb_grant.sv
module mwarb_grant #(
   parameter int unsigned N_PORTS = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                slot_d,
   input  logic [N_PORTS-1:0]                  req_d,
   input  logic [N_PORTS*N_PORTS-1:0]          mask_d,
   input  logic [N_PORTS-1:0]                  win_vld,
   input  logic [N_PORTS*$clog2(N_PORTS)-1:0]  win_idx,
   output logic [N_PORTS-1:0]                  grant,
   output logic                                grant_vld
);
   localparam int unsigned IDX_W = $clog2(N_PORTS);

   logic [N_PORTS-1:0] grant_nxt;

   always_comb begin
      for (int i = 0; i < N_PORTS; i++) begin
         grant_nxt[i] = slot_d && req_d[i] && (|mask_d[i*N_PORTS +: N_PORTS]);
         for (int o = 0; o < N_PORTS; o++) begin
            if (mask_d[i*N_PORTS+o] &&
                !(win_vld[o] && (win_idx[o*IDX_W +: IDX_W] == IDX_W'(i))))
               grant_nxt[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant     <= '0;
         grant_vld <= 1'b0;
      end else begin
         grant     <= grant_nxt;
         grant_vld <= slot_d;
      end
   end

   for (genvar o = 0; o < N_PORTS; o++) begin : g_col
      logic [N_PORTS-1:0] col;
      for (genvar i = 0; i < N_PORTS; i++) begin : g_bit
         assign col[i] = mask_d[i*N_PORTS+o];
      end
      p_one_per_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
         slot_d |=> $onehot0(grant & $past(col)));
   end

   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_vld |-> (grant == '0));

   p_need_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_d |=> ((grant & ~$past(req_d)) == '0));
endmodule

// File: rtl/maxwt_out_arbiter.sv
module maxwt_out_arbiter #(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned WT_W    = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       slot_start,
   input  logic [N_PORTS-1:0]         req_vld,
   input  logic [N_PORTS*WT_W-1:0]    req_wt,
   input  logic [N_PORTS*N_PORTS-1:0] req_mask,
   output logic [N_PORTS-1:0]         grant,
   output logic                       grant_vld
);
   import mwarb_pkg::*;

   localparam int unsigned IDX_W = $clog2(N_PORTS);
   localparam int unsigned LVLS  = IDX_W;
   localparam int unsigned LAT   = LVLS + 2;
   localparam int unsigned MW    = N_PORTS*N_PORTS;

   if ((N_PORTS < PORTS_MIN) || (N_PORTS > PORTS_MAX) ||
       ((N_PORTS & (N_PORTS-1)) != 0)) begin : g_bad_ports
      $error("N_PORTS must be a power of two in the allowed range");
   end
   if ((WT_W < WT_MIN) || (WT_W > WT_MAX)) begin : g_bad_wt
      $error("WT_W outside the allowed range");
   end

   // Stage 0: sample the slot.
   logic                    s0_slot;
   logic [N_PORTS-1:0]      s0_req;
   logic [N_PORTS*WT_W-1:0] s0_wt;
   logic [MW-1:0]           s0_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s0_slot <= 1'b0;
         s0_req  <= '0;
         s0_wt   <= '0;
         s0_mask <= '0;
      end else begin
         s0_slot <= slot_start;
         s0_req  <= slot_start ? req_vld  : '0;
         s0_wt   <= slot_start ? req_wt   : '0;
         s0_mask <= slot_start ? req_mask : '0;
      end
   end

   // One comparison tree per output.
   logic [N_PORTS-1:0]       win_vld;
   logic [N_PORTS*IDX_W-1:0] win_idx;

   for (genvar o = 0; o < N_PORTS; o++) begin : g_out
      logic [N_PORTS-1:0] leaf_vld;
      for (genvar i = 0; i < N_PORTS; i++) begin : g_leaf
         assign leaf_vld[i] = s0_req[i] & s0_mask[i*N_PORTS+o];
      end
      mwarb_tree #(.N_PORTS(N_PORTS), .WT_W(WT_W)) u_tree (
         .clk      (clk),
         .rst_n    (rst_n),
         .leaf_vld (leaf_vld),
         .leaf_wt  (s0_wt),
         .win_vld  (win_vld[o]),
         .win_idx  (win_idx[o*IDX_W +: IDX_W])
      );
   end

   // Request and mask ride alongside the tree.
   logic               d_slot [LVLS+1];
   logic [N_PORTS-1:0] d_req  [LVLS+1];
   logic [MW-1:0]      d_mask [LVLS+1];

   assign d_slot[0] = s0_slot;
   assign d_req[0]  = s0_req;
   assign d_mask[0] = s0_mask;

   for (genvar d = 1; d <= LVLS; d++) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            d_slot[d] <= 1'b0;
            d_req[d]  <= '0;
            d_mask[d] <= '0;
         end else begin
            d_slot[d] <= d_slot[d-1];
            d_req[d]  <= d_req[d-1];
            d_mask[d] <= d_mask[d-1];
         end
      end
   end

   mwarb_grant #(.N_PORTS(N_PORTS)) u_grant (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_d    (d_slot[LVLS]),
      .req_d     (d_req[LVLS]),
      .mask_d    (d_mask[LVLS]),
      .win_vld   (win_vld),
      .win_idx   (win_idx),
      .grant     (grant),
      .grant_vld (grant_vld)
   );

   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |-> ##LAT grant_vld);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> $past(slot_start, LAT));
endmodule

// File: tb/maxwt_out_arbiter_bench.sv
`timescale 1ns/1ps
module maxwt_out_arbiter_bench;
   localparam int N   = 4;
   localparam int W   = 4;
   localparam int LAT = 2 + $clog2(N);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slot_start = 1'b0;
   logic [N-1:0]     req_vld;
   logic [N*W-1:0]   req_wt;
   logic [N*N-1:0]   req_mask;
   logic [N-1:0]     grant;
   logic             grant_vld;

   logic [N-1:0] b_vld = '0;
   logic [W-1:0] b_wt   [N];
   logic [N-1:0] b_mask [N];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   always_comb begin
      req_vld = b_vld;
      for (int i = 0; i < N; i++) begin
         req_wt[i*W +: W]   = b_wt[i];
         req_mask[i*N +: N] = b_mask[i];
      end
   end

   maxwt_out_arbiter #(.N_PORTS(N), .WT_W(W)) u_maxwt_out_arbiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_start (slot_start),
      .req_vld    (req_vld),
      .req_wt     (req_wt),
      .req_mask   (req_mask),
      .grant      (grant),
      .grant_vld  (grant_vld)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_req(input int i, input logic v, input logic [W-1:0] w,
                          input logic [N-1:0] m);
      b_vld[i]  = v;
      b_wt[i]   = w;
      b_mask[i] = m;
   endtask

   task automatic clear_req();
      for (int i = 0; i < N; i++) set_req(i, 1'b0, '0, '0);
   endtask

   // Drive the current request set for one slot, check timing (R4) and grants.
   task automatic run_slot(input string tag, input logic [N-1:0] exp);
      @(negedge clk);
      slot_start = 1'b1;
      for (int k = 1; k <= LAT; k++) begin
         @(negedge clk);
         if (k == 1) begin
            slot_start = 1'b0;
            clear_req();
         end
         if (k < LAT) chk({"R4 early strobe ", tag}, 32'(grant_vld), 32'd0);
         else begin
            chk({"R4 strobe ", tag}, 32'(grant_vld), 32'd1);
            chk(tag, 32'(grant), 32'(exp));
         end
      end
      @(negedge clk);
      chk({"R4 strobe drop ", tag}, 32'(grant_vld), 32'd0);
      chk({"R4 grant quiet ", tag}, 32'(grant), 32'd0);
   endtask

   task automatic t_reset();
      chk("R4 reset grant_vld", 32'(grant_vld), 32'd0);
      chk("R4 reset grant", 32'(grant), 32'd0);
   endtask

   task automatic t_unicast();
      for (int i = 0; i < N; i++) set_req(i, 1'b1, W'(i+3), N'(1 << i));
      run_slot("R3 distinct unicast", 4'b1111);
   endtask

   task automatic t_max_weight();
      set_req(0, 1'b1, 4'd3, 4'b0100);
      set_req(1, 1'b1, 4'd9, 4'b0100);
      set_req(2, 1'b1, 4'd5, 4'b0100);
      set_req(3, 1'b1, 4'd7, 4'b0100);
      run_slot("R1 heaviest wins", 4'b0010);
   endtask

   task automatic t_tie();
      set_req(0, 1'b1, 4'd2, 4'b0010);
      set_req(1, 1'b1, 4'd8, 4'b0010);
      set_req(2, 1'b1, 4'd8, 4'b0010);
      set_req(3, 1'b1, 4'd8, 4'b0010);
      run_slot("R2 tie low index", 4'b0010);
      set_req(2, 1'b1, 4'd8, 4'b1000);
      set_req(3, 1'b1, 4'd8, 4'b1000);
      run_slot("R2 tie upper pair", 4'b0100);
   endtask

   task automatic t_invalid();
      set_req(3, 1'b0, 4'd15, 4'b0001);
      set_req(2, 1'b1, 4'd14, 4'b0000);
      set_req(1, 1'b1, 4'd1,  4'b0001);
      set_req(0, 1'b0, 4'd15, 4'b0001);
      run_slot("R5 invalid and empty mask ignored", 4'b0010);
   endtask

   task automatic t_multicast();
      set_req(0, 1'b1, 4'd9,  4'b0011);
      set_req(1, 1'b1, 4'd10, 4'b0010);
      set_req(2, 1'b1, 4'd1,  4'b0100);
      set_req(3, 1'b0, 4'd0,  4'b0000);
      run_slot("R6 multicast held back", 4'b0110);
      set_req(0, 1'b1, 4'd12, 4'b0011);
      set_req(1, 1'b1, 4'd10, 4'b0010);
      set_req(2, 1'b1, 4'd11, 4'b0001);
      run_slot("R6 multicast wins all", 4'b0001);
   endtask

   task automatic t_broadcast();
      set_req(3, 1'b1, 4'd15, 4'b1111);
      set_req(0, 1'b1, 4'd13, 4'b0001);
      set_req(1, 1'b1, 4'd2,  4'b0010);
      set_req(2, 1'b1, 4'd9,  4'b1000);
      run_slot("R7 broadcast wins", 4'b1000);
      // Broadcast beats input 0 on output 0 but loses output 3 on a tie.
      set_req(3, 1'b1, 4'd14, 4'b1111);
      set_req(0, 1'b1, 4'd13, 4'b0001);
      set_req(1, 1'b1, 4'd2,  4'b0010);
      set_req(2, 1'b1, 4'd14, 4'b1000);
      run_slot("R7 R6 broadcast held with idle outputs", 4'b0100);
   endtask

   task automatic load_pattern(input int p);
      clear_req();
      case (p)
         0: for (int i = 0; i < N; i++) set_req(i, 1'b1, W'(3 + 2*i), 4'b0100);
         1: begin
            set_req(0, 1'b1, 4'd12, 4'b0011);
            set_req(1, 1'b1, 4'd10, 4'b0010);
            set_req(2, 1'b1, 4'd11, 4'b0001);
         end
         default: for (int i = 0; i < N; i++) set_req(i, 1'b1, 4'd1, N'(1 << i));
      endcase
   endtask

   task automatic t_pipeline();
      logic [N-1:0] exp [3];
      exp[0] = 4'b1000;
      exp[1] = 4'b0001;
      exp[2] = 4'b1111;
      for (int k = 0; k <= LAT + 3; k++) begin
         @(negedge clk);
         if ((k >= LAT) && (k - LAT < 3)) begin
            chk("R8 back-to-back strobe", 32'(grant_vld), 32'd1);
            chk("R8 back-to-back grant", 32'(grant), 32'(exp[k-LAT]));
         end else if (k > 0) begin
            chk("R8 gap strobe", 32'(grant_vld), 32'd0);
         end
         if (k < 3) begin
            load_pattern(k);
            slot_start = 1'b1;
         end else begin
            slot_start = 1'b0;
            clear_req();
         end
      end
   endtask

   task automatic t_no_start();
      @(negedge clk);
      for (int i = 0; i < N; i++) set_req(i, 1'b1, 4'd9, 4'b1111);
      slot_start = 1'b0;
      for (int k = 0; k < LAT + 2; k++) begin
         @(negedge clk);
         chk("R9 no slot no strobe", 32'(grant_vld), 32'd0);
         chk("R9 no slot no grant", 32'(grant), 32'd0);
      end
      clear_req();
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         b_wt[i]   = '0;
         b_mask[i] = '0;
      end
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unicast();
      t_max_weight();
      t_tie();
      t_invalid();
      t_multicast();
      t_broadcast();
      t_pipeline();
      t_no_start();
      // R10 field positions are exercised by every scenario above.
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule